// File: doc/BRIEF.md
# Display Window Fetch Address Generator

This block walks video memory for the scan-out of a display window. It emits one 32-bit word address per clock toward a memory read port. A line-start strobe from the timing generator starts one display line. The line is a run of consecutive word addresses whose length is programmed minus one. Between lines the block steps forward by a programmable modulo. With a modulo of one the image is stored progressively. With a modulo of one plus the line pitch, one field of an interlaced image is read out of a frame stored line by line.

Two base addresses are held, one for each field of an interlaced frame. The frame-start strobe carries a field flag that picks the base for the new frame. All configuration is written into a pending copy. That copy moves into the active copy only at frame start, so a panning update never tears a frame. The active pixel depth is also presented as a byte count for the pixel unpacker downstream.

Top module: `dwin_fetch_addr`

## Requirements
- R1: After reset `fetch_valid` is low, `pix_bytes` reads 2, and line-start strobes produce no addresses until the first frame-start strobe.
- R2: The size register (`cfg_sel`=2) holds the line width in words minus one in bits [9:0], the line count minus one in bits [19:10] and the modulo in bits [29:20]. A line-start strobe accepted at one clock edge produces width consecutive word addresses, one per cycle, starting in the cycle that follows that edge.
- R3: The first address of each line after the first one equals the last address of the previous line plus the modulo.
- R4: At frame start the first line begins at the long-field base (`cfg_sel`=0) when `field_short` is 0, and at the short-field base (`cfg_sel`=1) when it is 1.
- R5: At most line-count lines are produced per frame. Further line-start strobes produce nothing until the next frame start.
- R6: A line-start strobe that arrives while a line is still being issued is ignored.
- R7: Writes to any register (`cfg_we` with `cfg_sel`) take effect only from the next frame-start strobe. A write made in the middle of a frame changes neither the addresses nor `pix_bytes` of that frame.
- R8: The mode register (`cfg_sel`=3) carries the bytes-per-pixel minus one code in bits [3:2]. Codes 1, 2 and 3 give a `pix_bytes` of 2, 3 and 4. The reserved code 0 also gives 2.
- R9: A frame-start strobe aborts any line in progress. `fetch_valid` is low in the following cycle, and a line-start strobe in the same cycle as the frame start is ignored.
- R10: Addresses wrap modulo 2^24 (the word-address width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 long base, 1 short base, 2 size, 3 mode |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Vertical retrace strobe; loads the pending configuration |
| line_start | input | 1 | Start-of-line fetch request |
| field_short | input | 1 | Field of the frame being started (1 = short field) |
| fetch_addr | output | 24 | Word address toward memory |
| fetch_valid | output | 1 | `fetch_addr` is valid this cycle |
| pix_bytes | output | 3 | Active bytes per pixel |

## Verification
Every result here is due one register stage after its cause. The first word address and `fetch_valid` appear in the cycle after the edge that samples a line start. Each further word follows one cycle later. A frame start makes new bases, sizes and depth visible in the cycle after its edge. The bench drives inputs on the falling edge. It advances a behavioural model, built on an address queue, by one clock for each drive. On every falling edge it compares valid, address and depth against the head of that queue, so each output is checked exactly in the cycle it is due.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
    localparam logic [1:0] SEL_LONG  = 2'd0;
    localparam logic [1:0] SEL_SHORT = 2'd1;
    localparam logic [1:0] SEL_SIZE  = 2'd2;
    localparam logic [1:0] SEL_MODE  = 2'd3;
    localparam int         DEPTH_LSB = 2;

    function automatic logic [2:0] bytes_of(input logic [1:0] code);
        return (code == 2'd0) ? 3'd2 : ({1'b0, code} + 3'd1);
    endfunction
endpackage

// File: rtl/dwf_cfg_regs.sv
module dwf_cfg_regs #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10,
    parameter int MOD_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              field_short,
    output logic [ADDR_W-1:0] frame_base,
    output logic [CNT_W-1:0]  words_m1,
    output logic [CNT_W-1:0]  lines_m1,
    output logic [MOD_W-1:0]  modulo,
    output logic [1:0]        depth_code
);
    import dwf_pkg::*;
    localparam int LINES_LSB = CNT_W;
    localparam int MOD_LSB   = 2 * CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] long_base;
        logic [ADDR_W-1:0] short_base;
        logic [CNT_W-1:0]  words_m1;
        logic [CNT_W-1:0]  lines_m1;
        logic [MOD_W-1:0]  modulo;
        logic [1:0]        depth;
    } cfg_t;

    typedef struct packed {
        cfg_t pend;
        cfg_t act;
    } state_t;

    state_t s_q, s_d;
    logic   cfg_unused;
    assign cfg_unused = ^cfg_wdata;

    always_comb begin
        s_d = s_q;
        if (frame_start) s_d.act = s_q.pend;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_LONG:  s_d.pend.long_base  = cfg_wdata[ADDR_W-1:0];
                SEL_SHORT: s_d.pend.short_base = cfg_wdata[ADDR_W-1:0];
                SEL_SIZE: begin
                    s_d.pend.words_m1 = cfg_wdata[CNT_W-1:0];
                    s_d.pend.lines_m1 = cfg_wdata[LINES_LSB +: CNT_W];
                    s_d.pend.modulo   = cfg_wdata[MOD_LSB +: MOD_W];
                end
                default:   s_d.pend.depth = cfg_wdata[DEPTH_LSB +: 2];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.pend.depth <= 2'd1;
            s_q.act.depth  <= 2'd1;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_base = field_short ? s_q.pend.short_base : s_q.pend.long_base;
    assign words_m1   = s_q.act.words_m1;
    assign lines_m1   = s_q.act.lines_m1;
    assign modulo     = s_q.act.modulo;
    assign depth_code = s_q.act.depth;

    assert_act_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(s_q.act));
endmodule

// File: rtl/dwf_addr_seq.sv
module dwf_addr_seq #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10,
    parameter int MOD_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [ADDR_W-1:0] frame_base,
    input  logic [CNT_W-1:0]  words_m1,
    input  logic [CNT_W-1:0]  lines_m1,
    input  logic [MOD_W-1:0]  modulo,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid
);
    localparam int LN_W = CNT_W + 1;

    typedef struct packed {
        logic              armed;
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] line_addr;
        logic [CNT_W-1:0]  word;
        logic [LN_W-1:0]   lines_done;
    } seq_t;

    seq_t            s_q, s_d;
    logic [LN_W-1:0] line_limit;
    logic            room;

    assign line_limit = {1'b0, lines_m1} + LN_W'(1);
    assign room       = s_q.armed && (s_q.lines_done < line_limit);

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.armed      = 1'b1;
            s_d.busy       = 1'b0;
            s_d.line_addr  = frame_base;
            s_d.lines_done = '0;
        end else if (s_q.busy) begin
            if (s_q.word == words_m1) begin
                s_d.busy       = 1'b0;
                s_d.line_addr  = s_q.addr + ADDR_W'(modulo);
                s_d.lines_done = s_q.lines_done + LN_W'(1);
            end else begin
                s_d.addr = s_q.addr + ADDR_W'(1);
                s_d.word = s_q.word + CNT_W'(1);
            end
        end else if (line_start && room) begin
            s_d.busy = 1'b1;
            s_d.addr = s_q.line_addr;
            s_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fetch_addr  = s_q.addr;
    assign fetch_valid = s_q.busy;

    assert_words_consecutive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && $past(fetch_valid) |-> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));
    assert_line_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lines_done <= line_limit);
    assert_busy_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && line_start && !frame_start |=>
            !fetch_valid || fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));
    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !fetch_valid);
endmodule

// File: rtl/dwin_fetch_addr.sv
module dwin_fetch_addr #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 10,
    parameter int MOD_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              field_short,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic [2:0]        pix_bytes
);
    import dwf_pkg::*;

    logic [ADDR_W-1:0] frame_base;
    logic [CNT_W-1:0]  words_m1, lines_m1;
    logic [MOD_W-1:0]  modulo;
    logic [1:0]        depth_code;

    dwf_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .field_short(field_short), .frame_base(frame_base),
        .words_m1(words_m1), .lines_m1(lines_m1), .modulo(modulo), .depth_code(depth_code)
    );

    dwf_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .frame_base(frame_base), .words_m1(words_m1), .lines_m1(lines_m1), .modulo(modulo),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid)
    );

    assign pix_bytes = bytes_of(depth_code);

    assert_depth_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_bytes >= 3'd2 && pix_bytes <= 3'd4);
    assert_depth_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(pix_bytes));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !fetch_valid);
endmodule

// File: tb/dwin_fetch_addr_tb.sv
module dwin_fetch_addr_tb;
    localparam int ADDR_W = 24;
    localparam int MASK   = (1 << ADDR_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        field_short = 1'b0;
    logic [ADDR_W-1:0] fetch_addr;
    logic        fetch_valid;
    logic [2:0]  pix_bytes;

    always #2 clk = ~clk;

    dwin_fetch_addr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .line_start(line_start), .field_short(field_short),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .pix_bytes(pix_bytes)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int q[$];
    int pend_long = 0, pend_short = 0, pend_words = 0, pend_lines = 0, pend_mod = 0, pend_depth = 1;
    int act_words = 0, act_lines = 0, act_mod = 0, act_depth = 1;
    int next_line = 0, issued = 0;
    bit armed = 1'b0;

    function automatic int size_word(int md, int ln, int wd);
        return (md << 20) | (ln << 10) | wd;
    endfunction

    function automatic int exp_bytes();
        return (act_depth == 0) ? 2 : act_depth + 1;
    endfunction

    task automatic model_edge(bit fs, bit ls, bit fld, bit we, int sel, int wd);
        if (fs) begin
            q.delete();
            act_words = pend_words; act_lines = pend_lines;
            act_mod = pend_mod; act_depth = pend_depth;
            next_line = fld ? pend_short : pend_long;
            issued = 0; armed = 1'b1;
        end else begin
            bit was_busy = (q.size() > 0);
            if (was_busy) void'(q.pop_front());
            if (ls && !was_busy && armed && issued <= act_lines) begin
                for (int i = 0; i <= act_words; i++) q.push_back((next_line + i) & MASK);
                next_line = (next_line + act_words + act_mod) & MASK;
                issued++;
            end
        end
        if (we) begin
            case (sel)
                0: pend_long = wd & MASK;
                1: pend_short = wd & MASK;
                2: begin pend_words = wd & 1023; pend_lines = (wd >> 10) & 1023; pend_mod = (wd >> 20) & 1023; end
                default: pend_depth = (wd >> 2) & 3;
            endcase
        end
    endtask

    task automatic compare();
        bit ev = (q.size() > 0);
        checks++;
        if (fetch_valid !== ev) begin
            errors++;
            $display("FAIL %s valid: actual %0b expected %0b", cur_req, fetch_valid, ev);
        end
        if (ev) begin
            checks++;
            if (int'(fetch_addr) != q[0]) begin
                errors++;
                $display("FAIL %s addr: actual %h expected %h", cur_req, fetch_addr, q[0]);
            end
        end
        checks++;
        if (int'(pix_bytes) != exp_bytes()) begin
            errors++;
            $display("FAIL R8 pix_bytes: actual %0d expected %0d", pix_bytes, exp_bytes());
        end
    endtask

    task automatic step(bit fs, bit ls, bit fld, bit we, int sel, int wd);
        @(negedge clk);
        compare();
        frame_start = fs; line_start = ls; field_short = fld;
        cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = wd;
        model_edge(fs, ls, fld, we, sel, wd);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(int sel, int wd);
        step(0, 0, 0, 1, sel, wd);
    endtask

    task automatic fstart(bit fld);
        step(1, 0, fld, 0, 0, 0);
    endtask

    task automatic line(int gap);
        step(0, 1, 0, 0, 0, 0);
        idle(gap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        checks++;
        if (fetch_valid !== 1'b0 || pix_bytes !== 3'd2) begin
            errors++;
            $display("FAIL R1 reset: actual valid %0b bytes %0d expected 0 2", fetch_valid, pix_bytes);
        end
        rst_n = 1'b1;
        idle(2);
        line(4);                        // R1: no frame start yet

        cur_req = "R7";
        wr(0, 'h1000);
        wr(1, 'h1004);
        wr(2, size_word(1, 2, 3));
        wr(3, 3 << 2);
        idle(3);                        // pending only

        cur_req = "R4"; fstart(0);
        cur_req = "R2"; line(6);
        cur_req = "R3"; line(6); line(6);
        cur_req = "R5"; line(6); line(6);

        cur_req = "R4";
        wr(2, size_word(5, 1, 3));      // interlaced: pitch 4 words
        fstart(1);
        cur_req = "R3"; line(6); line(6);

        cur_req = "R6";
        fstart(0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        idle(6);

        cur_req = "R7";
        wr(2, size_word(1, 3, 5));
        fstart(0);
        step(0, 1, 0, 0, 0, 0);
        wr(0, 'h2000);
        idle(8);
        line(8);
        fstart(0);
        line(8);

        cur_req = "R9";
        step(0, 1, 0, 0, 0, 0);
        idle(2);
        step(1, 1, 1, 0, 0, 0);
        idle(3);
        line(8);

        cur_req = "R10";
        wr(0, 'hFFFFFE);
        fstart(0);
        line(8);
        line(8);

        cur_req = "R8";
        for (int c = 0; c < 4; c++) begin
            wr(3, c << 2);
            idle(2);
            fstart(0);
            idle(2);
        end

        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule